// File: doc/BRIEF.md
# Serial Chien Search Unit

This block locates the roots of a binary BCH error locator polynomial whose coefficients are elements of GF(2^M). It handles polynomials of degree T. With the default configuration (M = 3, T = 2) the field is GF(8), generated by z^3 + z + 1, and the codeword is N = 2^M - 1 = 7 bits long. A load strobe captures the coefficients λ0..λT. The unit then tests one field element α^i per clock cycle for i = 0..N-1. For each one it emits an error-vector bit together with that bit's codeword position. One cycle after the last position it raises a done pulse.

The unit keeps one register per non-constant term. Register j is loaded with λj and is multiplied by the constant α^j on every step, so after i steps it holds λj·α^(ij). Each multiplication by α is a left shift followed by a conditional XOR of the reduction pattern. A term of order j chains j of these steps, so the design contains no general field multiplier. The root test adds the non-constant terms together and compares the sum against λ0. It does not add λ0 into the sum.

Top module: `chien_search_serial`

## Requirements
- R1: While reset is asserted and after its release, with no load, err_valid_o, err_bit_o and done_o are low.
- R2: On the cycle after a load strobe, err_valid_o is high and err_pos_o is 0 (i = 0). Each following cycle shows the next exponent i, at position N - i, giving the order 0, N-1, N-2, ..., 1.
- R3: err_bit_o is 1 exactly when λ1·α^i + λ2·α^(2i) (XOR sum over GF(2^3), reduction z^3 = z + 1) equals λ0. Element bit k is the coefficient of z^k. λj sits at lam_i[3j+2:3j].
- R4: err_valid_o stays high for exactly N = 7 consecutive cycles after a load. While err_valid_o is low, err_bit_o is low.
- R5: done_o is high for exactly one cycle. That cycle immediately follows the cycle showing position 1, and err_valid_o is low during it.
- R6: A load strobe during a search abandons it. The next cycle starts a new search at i = 0 with the new coefficients.
- R7: When the search has finished and no load arrives, the outputs stay idle: err_valid_o and done_o remain low.
- R8: An all-zero coefficient set reports every position as a root. A set with λ0 nonzero and λ1 = λ2 = 0 reports no roots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Strobe: capture coefficients and start a search |
| lam_i | input | (T+1)*M | Packed coefficients, λj at bits [j*M +: M] |
| err_valid_o | output | 1 | A tested position is presented this cycle |
| err_bit_o | output | 1 | Error-vector bit for err_pos_o |
| err_pos_o | output | $clog2(N) | Codeword position of the current bit |
| done_o | output | 1 | One-cycle pulse after the last position |

## Verification
The bench builds the block with its defaults: M = 3, reduction pattern 011 and T = 2. This is small enough to sweep all 512 coefficient sets, and the bench checks every one of the seven positions for each set against a field evaluation it computes itself. The sweep covers the degenerate sets: the all-zero set, sets with only a constant term, and sets whose roots repeat. A restart in the middle of a search and an idle stretch after completion are exercised separately. These show the load-priority and quiet-output behaviour.

// File: rtl/chien_pkg.sv
package chien_pkg;
   typedef enum logic {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;

   // number of nonzero field elements for a width
   function automatic int unsigned field_order(input int unsigned width);
      return (1 << width) - 1;
   endfunction
endpackage

// File: rtl/gf_alpha_step.sv
module gf_alpha_step #(
   parameter int unsigned    M   = 3,
   parameter logic [M-1:0]   RED = 3'b011
) (
   input  logic [M-1:0] a_i,
   output logic [M-1:0] y_i
);
   logic [M-1:0] shifted;
   logic [M-1:0] fold;

   always_comb begin
      shifted = {a_i[M-2:0], 1'b0};
      fold    = a_i[M-1] ? RED : '0;
      y_i     = shifted ^ fold;
   end
endmodule

// File: rtl/chien_term.sv
module chien_term #(
   parameter int unsigned    M   = 3,
   parameter logic [M-1:0]   RED = 3'b011,
   parameter int unsigned    J   = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic         adv_i,
   input  logic [M-1:0] lam_i,
   output logic [M-1:0] val_o
);
   logic [M-1:0] acc_q;
   logic [M-1:0] chain [0:J];

   assign chain[0] = acc_q;

   for (genvar k = 0; k < J; k++) begin : g_chain
      gf_alpha_step #(.M(M), .RED(RED)) u_step (
         .a_i (chain[k]),
         .y_i (chain[k+1])
      );
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         acc_q <= '0;
      end else if (load_i) begin
         acc_q <= lam_i;
      end else if (adv_i) begin
         acc_q <= chain[J];
      end
   end

   assign val_o = acc_q;
endmodule

// File: rtl/chien_ctrl.sv
module chien_ctrl
   import chien_pkg::*;
#(
   parameter int unsigned N  = 7,
   parameter int unsigned IW = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          load_i,
   output logic          run_o,
   output logic [IW-1:0] idx_o,
   output logic          done_o
);
   localparam logic [IW-1:0] LAST = IW'(N - 1);

   scan_state_e   state_q;
   logic [IW-1:0] idx_q;
   logic          done_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= SCAN_IDLE;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load_i) begin
            state_q <= SCAN_RUN;
            idx_q   <= '0;
         end else if (state_q == SCAN_RUN) begin
            if (idx_q == LAST) begin
               state_q <= SCAN_IDLE;
               idx_q   <= '0;
               done_q  <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign run_o  = (state_q == SCAN_RUN);
   assign idx_o  = idx_q;
   assign done_o = done_q;
endmodule

// File: rtl/chien_search_serial.sv
module chien_search_serial
   import chien_pkg::*;
#(
   parameter int unsigned    M   = 3,
   parameter logic [M-1:0]   RED = 3'b011,
   parameter int unsigned    T   = 2,
   localparam int unsigned   N   = field_order(M),
   localparam int unsigned   PW  = $clog2(N)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic [(T+1)*M-1:0] lam_i,
   output logic               err_valid_o,
   output logic               err_bit_o,
   output logic [PW-1:0]      err_pos_o,
   output logic               done_o
);
   if (M < 2 || M > 16) begin : g_bad_width
      $error("chien_search_serial: M out of range");
   end
   if (RED[0] != 1'b1) begin : g_bad_poly
      $error("chien_search_serial: reduction pattern needs a constant term");
   end
   if (T < 1 || T >= N) begin : g_bad_degree
      $error("chien_search_serial: T out of range");
   end

   logic          run;
   logic [PW-1:0] idx;
   logic [M-1:0]  lam0_q;
   logic [M-1:0]  term_v [T];
   logic [M-1:0]  sum;
   logic          hit;

   chien_ctrl #(.N(N), .IW(PW)) u_ctrl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .run_o  (run),
      .idx_o  (idx),
      .done_o (done_o)
   );

   for (genvar j = 1; j <= T; j++) begin : g_term
      chien_term #(.M(M), .RED(RED), .J(j)) u_term (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .load_i (load_i),
         .adv_i  (run),
         .lam_i  (lam_i[j*M +: M]),
         .val_o  (term_v[j-1])
      );
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lam0_q <= '0;
      end else if (load_i) begin
         lam0_q <= lam_i[M-1:0];
      end
   end

   always_comb begin
      sum = '0;
      for (int j = 0; j < T; j++) begin
         sum = sum ^ term_v[j];
      end
   end

   assign hit         = (sum == lam0_q);
   assign err_valid_o = run;
   assign err_bit_o   = run & hit;
   assign err_pos_o   = (idx == '0) ? '0 : PW'(N) - idx;
endmodule

// File: rtl/chien_search_serial_chk.sv
module chien_search_serial_chk #(
   parameter int unsigned N  = 7,
   parameter int unsigned PW = 3
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          load_i,
   input logic          err_valid_o,
   input logic          err_bit_o,
   input logic [PW-1:0] err_pos_o,
   input logic          done_o
);
   localparam logic [PW-1:0] TOP = PW'(N - 1);
   localparam logic [PW-1:0] END = PW'(1);

   p_load_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (err_valid_o && err_pos_o == '0));

   p_pos_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_valid_o && !load_i && err_pos_o != END) |=>
         (err_valid_o && err_pos_o == (($past(err_pos_o) == '0) ? TOP : $past(err_pos_o) - 1'b1)));

   p_bit_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !err_valid_o |-> !err_bit_o);

   p_done_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_valid_o && err_pos_o == END && !load_i) |=> (done_o && !err_valid_o));

   p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!err_valid_o && !load_i) |=> !err_valid_o);
endmodule

bind chien_search_serial chien_search_serial_chk #(.N(N), .PW(PW)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .load_i      (load_i),
   .err_valid_o (err_valid_o),
   .err_bit_o   (err_bit_o),
   .err_pos_o   (err_pos_o),
   .done_o      (done_o)
);

// File: tb/chien_search_serial_bench.sv
`timescale 1ns/1ps
module chien_search_serial_bench;
   localparam int N = 7;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       load_i = 1'b0;
   logic [8:0] lam_i = '0;
   logic       err_valid_o;
   logic       err_bit_o;
   logic [2:0] err_pos_o;
   logic       done_o;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk_i = ~clk_i;

   chien_search_serial u_chien_search_serial (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load_i),
      .lam_i       (lam_i),
      .err_valid_o (err_valid_o),
      .err_bit_o   (err_bit_o),
      .err_pos_o   (err_pos_o),
      .done_o      (done_o)
   );

   function automatic logic [2:0] gmul(input logic [2:0] a, input logic [2:0] b);
      logic [2:0] r = '0;
      logic [2:0] x = a;
      for (int k = 0; k < 3; k++) begin
         if (b[k]) r = r ^ x;
         x = x[2] ? ({x[1:0], 1'b0} ^ 3'b011) : {x[1:0], 1'b0};
      end
      return r;
   endfunction

   function automatic logic [2:0] apow(input int e);
      logic [2:0] r = 3'b001;
      for (int k = 0; k < e; k++) r = gmul(r, 3'b010);
      return r;
   endfunction

   function automatic bit is_root(input logic [8:0] lam, input int i);
      logic [2:0] v = lam[2:0] ^ gmul(lam[5:3], apow(i)) ^ gmul(lam[8:6], apow(2 * i));
      return v == 3'b000;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // drive a load at a negedge, then check i = 0..stop-1
   task automatic scan(input logic [8:0] lam, input int stop, input bit full);
      load_i = 1'b1;
      lam_i  = lam;
      @(negedge clk_i);
      load_i = 1'b0;
      for (int i = 0; i < stop; i++) begin
         chk("R2 valid", err_valid_o, 1);
         chk("R2 position", err_pos_o, (i == 0) ? 0 : N - i);
         chk("R3 error bit", err_bit_o, is_root(lam, i));
         chk("R5 no done during scan", done_o, 0);
         if (i < stop - 1 || full) @(negedge clk_i);
      end
      if (full) begin
         chk("R5 done pulse", done_o, 1);
         chk("R4 valid ends after N", err_valid_o, 0);
         chk("R4 bit low when idle", err_bit_o, 0);
         @(negedge clk_i);
         chk("R5 done one cycle", done_o, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      chk("R1 valid in reset", err_valid_o, 0);
      chk("R1 done in reset", done_o, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk("R1 valid after reset", err_valid_o, 0);
      chk("R1 bit after reset", err_bit_o, 0);
      chk("R1 done after reset", done_o, 0);

      // R8 degenerate sets
      scan(9'b000_000_000, N, 1'b1);
      scan(9'b000_000_101, N, 1'b1);

      // exhaustive sweep (R2..R5)
      for (int v = 0; v < 512; v++) scan(9'(v), N, 1'b1);

      // R8 explicit: all-zero set marks every position
      load_i = 1'b1; lam_i = '0;
      @(negedge clk_i);
      load_i = 1'b0;
      for (int i = 0; i < N; i++) begin
         chk("R8 all-zero root", err_bit_o, 1);
         @(negedge clk_i);
      end
      @(negedge clk_i);

      // R6 restart in the middle of a search
      scan(9'b011_101_110, 3, 1'b0);
      @(negedge clk_i);
      scan(9'b001_010_011, N, 1'b1);

      // R7 idle stretch after completion
      for (int k = 0; k < 10; k++) begin
         chk("R7 idle valid", err_valid_o, 0);
         chk("R7 idle done", done_o, 0);
         @(negedge clk_i);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule